// File: doc/BRIEF.md
# Double-Buffered Photon-Counting Pixel Array Readout

This block holds one hit counter per pixel of a small photon-counting imager. Each counter adds one for every single-cycle discriminator pulse that arrives while the exposure gate is high. A frame-end strobe moves every count into a second copy in one cycle and clears the live counters. The next exposure then runs while the stored frame drains over a 32-bit word bus with a valid/ready handshake.

The counting depth is chosen at run time: 4, 8 or 12 bits. The depth sets the saturation ceiling. It also sets how many pixels are packed into each word, so a shallow depth drains a frame in fewer words. A frame-end strobe that comes while the stored frame is still draining throws away the frame just ended. In that case the stored data is left intact and a sticky overrun flag is raised.

Top module: `pixro_top`

## Requirements
- R1: After reset, out_valid, out_last and overrun are low, and the depth is 8 bits (mode code 2'b01).
- R2: A hit in a cycle with expose high raises that pixel's count by exactly one. A hit while expose is low has no effect.
- R3: A counter that reaches its depth's ceiling (15, 255 or 4095) holds that value and never wraps.
- R4: A frame_end strobe accepted at one edge copies all counts to the buffer and clears the counters. out_valid is high from that edge onward. A hit in the strobe cycle counts toward the new frame.
- R5: Mode code 2'b00 (4-bit) packs eight pixels per word, pixel 8w+j in bits [4j+3:4j], giving 8 words per 64-pixel frame.
- R6: Mode code 2'b01 (8-bit) packs four pixels per word, pixel 4w+j in bits [8j+7:8j], giving 16 words per frame.
- R7: Mode code 2'b10 (12-bit) packs two pixels per word, pixel 2w+j in bits [16j+11:16j] with bits [16j+15:16j+12] zero, giving 32 words per frame.
- R8: out_last is high on the final word of each frame and on no other word.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: A frame_end while a frame is still buffered leaves the buffer unchanged, clears the counters and sets overrun. Overrun stays high until reset.
- R11: A mode write takes effect only while expose is low and no frame is buffered. Writes at other times, and writes of code 2'b11, are ignored.
- R12: Counting continues while a buffered frame is waiting or draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| expose | input | 1 | Exposure gate |
| hit | input | ROWS*COLS | One-cycle discriminator pulses, one bit per pixel in raster order |
| frame_end | input | 1 | Frame boundary strobe |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 2 | Requested depth: 00 = 4-bit, 01 = 8-bit, 10 = 12-bit |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Packed pixel word |
| out_valid | output | 1 | Word available |
| out_last | output | 1 | Final word of the frame |
| overrun | output | 1 | Sticky flag for a discarded frame |

## Verification
A count adds up at the edge that samples the hit, so its effect is seen only in the stored frame. A frame_end driven before edge k makes out_valid high just after edge k. The bench checks that flag one cycle after the strobe. Each word is taken in the cycle it is shown and is consumed at the next edge while out_ready is high. The bench drives and samples 2 ns after the rising edge, so every value it reads is settled, and it compares each word with a packing built from the hit counts it applied.

// File: rtl/pixro_pkg.sv
package pixro_pkg;

    localparam int CNT_W = 12;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        DEPTH4  = 2'b00,
        DEPTH8  = 2'b01,
        DEPTH12 = 2'b10
    } depth_e;

    typedef struct packed {
        logic   capture;
        logic   clear;
        logic   expose;
        depth_e depth;
    } frame_ctl_t;

    function automatic logic [CNT_W-1:0] depth_max(depth_e d);
        case (d)
            DEPTH4:  return CNT_W'(15);
            DEPTH8:  return CNT_W'(255);
            default: return CNT_W'(4095);
        endcase
    endfunction

    function automatic int lanes_per_word(depth_e d);
        case (d)
            DEPTH4:  return 8;
            DEPTH8:  return 4;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/pixro_cell.sv
module pixro_cell
    import pixro_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frame_ctl_t       ctl,
    input  logic             hit,
    output logic [CNT_W-1:0] shadow_q
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ceil;
    logic             inc;

    assign ceil = depth_max(ctl.depth);
    assign inc  = ctl.expose & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else begin
            if (ctl.clear)
                cnt_q <= inc ? CNT_W'(1) : '0;
            else if (inc && (cnt_q < ceil))
                cnt_q <= cnt_q + CNT_W'(1);
            if (ctl.capture)
                shadow_q <= cnt_q;
        end
    end

    // R2: one qualifying hit adds exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clear && inc && (cnt_q < ceil)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: no hit or no gate leaves the count alone
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clear && !inc) |=> $stable(cnt_q));

    // R3: the ceiling holds
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clear && (cnt_q == ceil)) |=> (cnt_q == $past(cnt_q)));

    // R4: the buffer takes the count of the closing frame
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        ctl.capture |=> (shadow_q == $past(cnt_q)));

endmodule

// File: rtl/pixro_ctrl.sv
module pixro_ctrl
    import pixro_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expose,
    input  logic       frame_end,
    input  logic       mode_wr,
    input  logic [1:0] mode_sel,
    input  logic       frame_done,
    output frame_ctl_t ctl,
    output logic       full_q,
    output logic       overrun_q
);

    depth_e depth_q;
    logic   take;
    logic   mode_ok;

    assign take    = frame_end && !full_q;
    assign mode_ok = mode_wr && !expose && !full_q && !frame_end && (mode_sel != 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q   <= DEPTH8;
            full_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (take)
                full_q <= 1'b1;
            else if (frame_done)
                full_q <= 1'b0;
            if (frame_end && full_q)
                overrun_q <= 1'b1;
            if (mode_ok)
                depth_q <= depth_e'(mode_sel);
        end
    end

    always_comb begin
        ctl.capture = take;
        ctl.clear   = frame_end | mode_ok;
        ctl.expose  = expose;
        ctl.depth   = depth_q;
    end

    // R10: overrun is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_q |=> overrun_q);

    // R10: a held frame is not replaced
    a_r10_keep_full: assert property (@(posedge clk) disable iff (rst)
        (full_q && !frame_done) |=> full_q);

    // R11: depth frozen while busy
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (expose || full_q) |=> (depth_q == $past(depth_q)));

endmodule

// File: rtl/pixro_stream.sv
module pixro_stream
    import pixro_pkg::*;
#(
    parameter int NPIX = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  depth_e           depth,
    input  logic             full,
    input  logic [CNT_W-1:0] shadow [NPIX],
    input  logic             out_ready,
    output logic [BUS_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_last,
    output logic             frame_done
);

    localparam int WIDX_W = $clog2(NPIX / 2);

    logic [WIDX_W-1:0] widx_q;
    logic [WIDX_W-1:0] wlast;
    logic              fire;

    assign wlast      = WIDX_W'(NPIX / lanes_per_word(depth) - 1);
    assign out_valid  = full;
    assign out_last   = full && (widx_q == wlast);
    assign fire       = full && out_ready;
    assign frame_done = fire && (widx_q == wlast);

    always_ff @(posedge clk) begin
        if (rst)
            widx_q <= '0;
        else if (fire)
            widx_q <= (widx_q == wlast) ? '0 : widx_q + WIDX_W'(1);
    end

    always_comb begin
        out_data = '0;
        case (depth)
            DEPTH4: begin
                for (int j = 0; j < 8; j++) begin
                    int idx;
                    idx = int'(widx_q) * 8 + j;
                    if (idx < NPIX)
                        out_data[j*4 +: 4] = shadow[idx][3:0];
                end
            end
            DEPTH8: begin
                for (int j = 0; j < 4; j++) begin
                    int idx;
                    idx = int'(widx_q) * 4 + j;
                    if (idx < NPIX)
                        out_data[j*8 +: 8] = shadow[idx][7:0];
                end
            end
            default: begin
                for (int j = 0; j < 2; j++) begin
                    int idx;
                    idx = int'(widx_q) * 2 + j;
                    if (idx < NPIX)
                        out_data[j*16 +: CNT_W] = shadow[idx];
                end
            end
        endcase
    end

    // R9: a stalled word holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: last marks a presented word
    a_r8_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R8: after the final word the next frame starts at word zero
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (widx_q == '0));

endmodule

// File: rtl/pixro_top.sv
module pixro_top
    import pixro_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 expose,
    input  logic [ROWS*COLS-1:0] hit,
    input  logic                 frame_end,
    input  logic                 mode_wr,
    input  logic [1:0]           mode_sel,
    input  logic                 out_ready,
    output logic [31:0]          out_data,
    output logic                 out_valid,
    output logic                 out_last,
    output logic                 overrun
);

    localparam int NPIX = ROWS * COLS;

    frame_ctl_t       ctl;
    logic             full;
    logic             frame_done;
    logic [CNT_W-1:0] shadow [NPIX];

    pixro_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .expose     (expose),
        .frame_end  (frame_end),
        .mode_wr    (mode_wr),
        .mode_sel   (mode_sel),
        .frame_done (frame_done),
        .ctl        (ctl),
        .full_q     (full),
        .overrun_q  (overrun)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pixro_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .hit      (hit[p]),
            .shadow_q (shadow[p])
        );
    end

    pixro_stream #(.NPIX(NPIX)) u_stream (
        .clk        (clk),
        .rst        (rst),
        .depth      (ctl.depth),
        .full       (full),
        .shadow     (shadow),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .frame_done (frame_done)
    );

    // R1: reset leaves the bus idle
    a_r1_idle: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !overrun));

endmodule

// File: tb/pixro_top_tb.sv
module pixro_top_tb;

    localparam int NPIX = 64;

    logic            clk = 0;
    logic            rst;
    logic            expose;
    logic [NPIX-1:0] hit;
    logic            frame_end;
    logic            mode_wr;
    logic [1:0]      mode_sel;
    logic            out_ready;
    logic [31:0]     out_data;
    logic            out_valid;
    logic            out_last;
    logic            overrun;

    int checks = 0;
    int errors = 0;
    int nh   [NPIX];
    int expc [NPIX];

    always #10 clk = ~clk;

    pixro_top u_dut (
        .clk(clk), .rst(rst), .expose(expose), .hit(hit), .frame_end(frame_end),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .out_ready(out_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .overrun(overrun)
    );

    task automatic cyc;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ceil_of(int mode);
        return (mode == 0) ? 15 : (mode == 1) ? 255 : 4095;
    endfunction

    function automatic int lanes_of(int mode);
        return (mode == 0) ? 8 : (mode == 1) ? 4 : 2;
    endfunction

    task automatic clear_hits;
        for (int p = 0; p < NPIX; p++) nh[p] = 0;
    endtask

    task automatic set_expect(input int mode);
        for (int p = 0; p < NPIX; p++)
            expc[p] = (nh[p] > ceil_of(mode)) ? ceil_of(mode) : nh[p];
    endtask

    function automatic logic [31:0] exp_word(int w, int mode);
        logic [31:0] v;
        int ln;
        int sw;
        v  = '0;
        ln = lanes_of(mode);
        sw = 32 / ln;
        for (int j = 0; j < ln; j++)
            v = v | (32'(expc[w*ln + j]) << (j * sw));
        return v;
    endfunction

    task automatic run_hits(input int ncyc);
        expose = 1;
        for (int c = 0; c < ncyc; c++) begin
            for (int p = 0; p < NPIX; p++) hit[p] = (c < nh[p]);
            cyc;
        end
        hit    = '0;
        expose = 0;
    endtask

    task automatic end_frame;
        frame_end = 1;
        cyc;
        frame_end = 0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        mode_sel = m;
        mode_wr  = 1;
        cyc;
        mode_wr  = 0;
    endtask

    task automatic read_frame(input string req, input int mode);
        int k;
        int nw;
        int guard;
        k     = 0;
        guard = 0;
        nw    = NPIX / lanes_of(mode);
        out_ready = 1;
        while (guard < 40) begin
            guard++;
            if (out_valid) begin
                chk({req, " word"}, out_data, exp_word(k, mode));
                chk("R8 last flag", 32'(out_last), 32'(k == nw - 1));
                k++;
                if (out_last) begin
                    cyc;
                    break;
                end
            end
            cyc;
        end
        out_ready = 0;
        chk({req, " word count"}, 32'(k), 32'(nw));
        chk("R8 valid drops after last", 32'(out_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 out_last", 32'(out_last), 0);
        chk("R1 overrun", 32'(overrun), 0);
    endtask

    task automatic t_mode8_default;
        clear_hits();
        for (int p = 0; p < NPIX; p++) nh[p] = p % 20;
        nh[5] = 260;
        run_hits(260);
        hit = '1;
        repeat (3) cyc;
        hit = '0;
        set_expect(1);
        end_frame();
        chk("R4 valid one cycle after strobe", 32'(out_valid), 1);
        read_frame("R6 R1 R2 R3 8-bit", 1);
    endtask

    task automatic t_same_cycle;
        logic [31:0] held;
        clear_hits();
        expose = 1;
        hit[3] = 1;
        repeat (2) cyc;
        hit[7]    = 1;
        frame_end = 1;
        cyc;
        frame_end = 0;
        hit       = '0;
        chk("R4 valid after strobe", 32'(out_valid), 1);
        held   = out_data;
        hit[2] = 1;
        for (int c = 0; c < 3; c++) begin
            cyc;
            chk("R9 stalled data held", out_data, held);
            chk("R9 stalled valid held", 32'(out_valid), 1);
        end
        hit    = '0;
        expose = 0;
        nh[3] = 2;
        set_expect(1);
        read_frame("R4 first frame", 1);
        end_frame();
        clear_hits();
        nh[2] = 3; nh[3] = 1; nh[7] = 1;
        set_expect(1);
        read_frame("R12 R4 counted during readout", 1);
    endtask

    task automatic t_mode_ignore;
        expose = 1;
        write_mode(2'b00);
        expose = 0;
        write_mode(2'b11);
        clear_hits();
        set_expect(1);
        end_frame();
        write_mode(2'b00);
        read_frame("R11 busy writes ignored", 1);
    endtask

    task automatic t_mode4;
        write_mode(2'b00);
        clear_hits();
        for (int p = 0; p < NPIX; p++) nh[p] = (p % 2 == 0) ? 20 : p % 16;
        run_hits(20);
        set_expect(0);
        end_frame();
        read_frame("R5 R3 4-bit", 0);
    endtask

    task automatic t_mode12;
        write_mode(2'b10);
        clear_hits();
        for (int p = 0; p < NPIX; p++) nh[p] = p;
        nh[0] = 4100;
        nh[1] = 300;
        run_hits(4100);
        set_expect(2);
        end_frame();
        read_frame("R7 R3 12-bit", 2);
    endtask

    task automatic t_overrun;
        write_mode(2'b01);
        clear_hits();
        nh[0] = 1;
        run_hits(1);
        end_frame();
        chk("R10 no overrun yet", 32'(overrun), 0);
        clear_hits();
        nh[0] = 5;
        run_hits(5);
        end_frame();
        chk("R10 overrun set", 32'(overrun), 1);
        clear_hits();
        nh[0] = 1;
        set_expect(1);
        read_frame("R10 buffer kept", 1);
        chk("R10 overrun sticky", 32'(overrun), 1);
        clear_hits();
        nh[1] = 2;
        run_hits(2);
        set_expect(1);
        end_frame();
        read_frame("R10 discarded frame cleared", 1);
        chk("R10 overrun still set", 32'(overrun), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; expose = 0; hit = '0; frame_end = 0;
        mode_wr = 0; mode_sel = 2'b01; out_ready = 0;
        repeat (3) cyc;
        rst = 0;
        cyc;
        t_reset();
        t_mode8_default();
        t_same_cycle();
        t_mode_ignore();
        t_mode4();
        t_mode12();
        t_overrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule